// File: doc/BRIEF.md
# Self-Checking One-Hot Control Sequencer

This block steps a control flow through a fixed chain of states. It holds that state in a one-hot register, with one flip-flop per state. From idle, a start command enters the first step. Each advance command moves one step along the chain. Leaving the last step returns the flow to idle, and an abort command returns it to idle from any step.

A parity guard watches the state register on every cycle. It forms an XNOR over all state bits. A legal one-hot code always has an odd number of ones, so an XNOR result of 1 marks the code as corrupt. This covers the all-zero code and any code where two bits are set. The reduction is split into small groups. Each group is no wider than one lookup table, and a register follows every level of the tree, so the guard keeps pace with a fast clock. The cost is latency: the alarm appears a fixed number of cycles after the bad code, equal to the tree depth. While the alarm is high, the sequencer is reloaded with the idle code.

A fault-injection port XORs a mask into the state register. This lets a bench, or a built-in self-test, model upsets of single bits or of several bits.

Top module: `onehot_sequencer`

## Requirements
- R1: After synchronous active-high reset, `state_onehot` is the idle code 0x01 (bit 0 set), `state_idx` is 0 and `illegal` is 0.
- R2: In idle, `start` loads the first step (bit 1, 0x02). In any other state, `start` has no effect.
- R3: In step k (bit k, 1 <= k <= N_STATES-2), `advance` loads bit k+1. In the last step (bit N_STATES-1), `advance` loads idle. In idle, `advance` has no effect. With no command, the state holds.
- R4: `abort` in any step loads idle and takes priority over `advance`. In idle, `abort` has no effect.
- R5: When the state register takes a code with an even number of set bits, `illegal` is 1 exactly LAT clock edges later, and not before. LAT equals the tree depth, which is 2 for the defaults. Such codes include a single bit cleared (zero bits set) and a single extra bit set (two bits set).
- R6: On any edge where `illegal` is 1 and `flip_en` is 0, the state register loads idle (0x01), overriding `start`, `advance` and `abort`.
- R7: After a single injected upset with no further commands, `illegal` stays 1 for exactly LAT+1 cycles. It then returns to 0 once the idle code has passed through every tree level.
- R8: A code with three bits set has odd parity and is not flagged: `illegal` stays 0.
- R9: `state_idx` is the position of the lowest set bit of the state register, and 0 when no bit is set.
- R10: When `flip_en` is 1, the next edge loads the current state XOR `flip_mask`, overriding every other transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Leave idle for the first step |
| advance | input | 1 | Move to the next step |
| abort | input | 1 | Return to idle from any step |
| flip_en | input | 1 | Apply the fault mask at the next edge |
| flip_mask | input | N_STATES | Bits to invert in the state register |
| state_onehot | output | N_STATES | Current state register |
| state_idx | output | $clog2(N_STATES) | Lowest set bit position of the state |
| illegal | output | 1 | Registered even-parity alarm from the last tree level |

## Verification
The case of interest is the alarm-driven reload to idle landing on the same edge as a normal transition request. To provoke it, the bench injects an extra bit while the sequencer sits mid-chain and holds `advance` high through the whole alarm latency. The two-bit code then walks along the chain until the alarm rises. The bench judges the outcome by requiring that the edge after the alarm rises loads 0x01 rather than a next step, and that the alarm still falls exactly LAT+1 cycles after it rose.

// File: rtl/ohseq_pkg.sv
package ohseq_pkg;

    // Commands that drive the transition logic.
    typedef struct packed {
        logic start;
        logic advance;
        logic abort;
    } seq_cmd_t;

    // Width of tree level l when n inputs are reduced w at a time.
    function automatic int unsigned level_width(int unsigned n, int unsigned w, int unsigned l);
        int unsigned m;
        m = n;
        for (int unsigned k = 0; k < l; k++) begin
            m = (m + w - 1) / w;
        end
        return m;
    endfunction

    // Number of registered levels needed to reach a single bit.
    function automatic int unsigned stage_count(int unsigned n, int unsigned w);
        int unsigned m;
        int unsigned c;
        m = n;
        c = 0;
        while (m > 1) begin
            m = (m + w - 1) / w;
            c++;
        end
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/ohseq_next.sv
module ohseq_next
    import ohseq_pkg::*;
#(
    parameter int unsigned N_STATES = 8
) (
    input  logic [N_STATES-1:0] cur,
    input  seq_cmd_t            cmd,
    input  logic                alarm,
    output logic [N_STATES-1:0] nxt
);
    localparam logic [N_STATES-1:0] IDLE_CODE = N_STATES'(1);

    // Each set bit contributes its own successor, so legal codes stay
    // one-hot and corrupted codes keep their shape until the alarm acts.
    always_comb begin
        nxt = '0;
        for (int i = 0; i < N_STATES; i++) begin
            if (cur[i]) begin
                if (i == 0) begin
                    if (cmd.start) nxt[1] = 1'b1;
                    else           nxt[0] = 1'b1;
                end else if (cmd.abort) begin
                    nxt[0] = 1'b1;
                end else if (cmd.advance) begin
                    nxt[(i + 1) % N_STATES] = 1'b1;
                end else begin
                    nxt[i] = 1'b1;
                end
            end
        end
        if (alarm) nxt = IDLE_CODE;
    end

endmodule

// File: rtl/ohseq_xnor_tree.sv
module ohseq_xnor_tree
    import ohseq_pkg::*;
#(
    parameter int unsigned N_IN  = 8,
    parameter int unsigned LUT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] din,
    output logic            even_flag
);
    localparam int unsigned LVLS = stage_count(N_IN, LUT_W);

    for (genvar l = 0; l < LVLS; l++) begin : stg
        localparam int unsigned WI = level_width(N_IN, LUT_W, l);
        localparam int unsigned WO = level_width(N_IN, LUT_W, l + 1);
        localparam bit          LAST = (l == LVLS - 1);
        // Reset to the idle code's partial parity so no false alarm follows reset.
        localparam logic [WO-1:0] RST_VAL = LAST ? '0 : WO'(1);

        logic [WI-1:0] src;
        logic [WO-1:0] par;
        logic [WO-1:0] q;

        if (l == 0) begin : g_src0
            assign src = din;
        end else begin : g_srcn
            assign src = stg[l-1].q;
        end

        for (genvar g = 0; g < WO; g++) begin : grp
            localparam int unsigned LO = g * LUT_W;
            localparam int unsigned HI = (((LO + LUT_W) < WI) ? (LO + LUT_W) : WI) - 1;
            assign par[g] = ^src[HI:LO];
        end

        always_ff @(posedge clk) begin
            if (rst)       q <= RST_VAL;
            else if (LAST) q <= ~par;
            else           q <= par;
        end
    end

    assign even_flag = stg[LVLS-1].q[0];

endmodule

// File: rtl/onehot_sequencer.sv
module onehot_sequencer
    import ohseq_pkg::*;
#(
    parameter int unsigned N_STATES = 8,
    parameter int unsigned LUT_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic                        advance,
    input  logic                        abort,
    input  logic                        flip_en,
    input  logic [N_STATES-1:0]         flip_mask,
    output logic [N_STATES-1:0]         state_onehot,
    output logic [$clog2(N_STATES)-1:0] state_idx,
    output logic                        illegal
);
    localparam int unsigned IW = $clog2(N_STATES);
    localparam logic [N_STATES-1:0] IDLE_CODE = N_STATES'(1);
    localparam logic [N_STATES-1:0] STEP1     = N_STATES'(2);

    logic [N_STATES-1:0] state_q;
    logic [N_STATES-1:0] state_d;
    seq_cmd_t            cmd;

    assign cmd = '{start: start, advance: advance, abort: abort};

    ohseq_next #(.N_STATES(N_STATES)) u_next (
        .cur   (state_q),
        .cmd   (cmd),
        .alarm (illegal),
        .nxt   (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst)          state_q <= IDLE_CODE;
        else if (flip_en) state_q <= state_q ^ flip_mask;
        else              state_q <= state_d;
    end

    ohseq_xnor_tree #(.N_IN(N_STATES), .LUT_W(LUT_W)) u_tree (
        .clk       (clk),
        .rst       (rst),
        .din       (state_q),
        .even_flag (illegal)
    );

    always_comb begin
        state_idx = '0;
        for (int i = N_STATES - 1; i >= 0; i--) begin
            if (state_q[i]) state_idx = IW'(i);
        end
    end

    assign state_onehot = state_q;

    // R6: alarm reloads idle whatever command is present
    p_alarm_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (illegal && !flip_en) |=> (state_q == IDLE_CODE));

    // R2: start from idle enters the first step
    p_start_step1_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == IDLE_CODE && start && !illegal && !flip_en) |=> (state_q == STEP1));

    // R4: abort from a legal step returns to idle
    p_abort_idle_r4: assert property (@(posedge clk) disable iff (rst)
        ($onehot(state_q) && !state_q[0] && abort && !illegal && !flip_en)
        |=> (state_q == IDLE_CODE));

    // R3: legal codes stay one-hot under any command mix
    p_keep_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        ($onehot(state_q) && !illegal && !flip_en) |=> $onehot(state_q));

    // R9: decoded index points at a set bit for legal codes
    p_idx_match_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot(state_q) |-> state_q[state_idx]);

endmodule

// File: tb/onehot_sequencer_test.sv
module onehot_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int LAT = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0, advance = 1'b0, abort = 1'b0, flip_en = 1'b0;
    logic [N-1:0] flip_mask = '0;
    logic [N-1:0] state_onehot;
    logic [2:0]   state_idx;
    logic         illegal;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    onehot_sequencer uut (
        .clk(clk), .rst(rst), .start(start), .advance(advance), .abort(abort),
        .flip_en(flip_en), .flip_mask(flip_mask),
        .state_onehot(state_onehot), .state_idx(state_idx), .illegal(illegal)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_state(string req, int exp);
        check(state_onehot == N'(exp), req, int'(state_onehot), exp);
    endtask

    task automatic chk_flag(string req, int exp);
        check(illegal == 1'(exp), req, int'(illegal), exp);
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 0; advance = 0; abort = 0; flip_en = 0; flip_mask = '0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic t_reset_r1();
        do_reset();
        chk_state("R1 state", 'h01);
        check(state_idx == 0, "R1 idx", int'(state_idx), 0);
        chk_flag("R1 flag", 0);
        tick(); tick();
        chk_flag("R1 flag after release", 0);
    endtask

    task automatic t_walk_r2_r3();
        advance = 1; tick(); advance = 0;
        chk_state("R3 advance in idle ignored", 'h01);
        tick();
        chk_state("R3 hold with no command", 'h01);
        start = 1; tick(); start = 0;
        chk_state("R2 start enters step1", 'h02);
        check(state_idx == 1, "R9 idx step1", int'(state_idx), 1);
        start = 1; tick(); start = 0;
        chk_state("R2 start in step ignored", 'h02);
        for (int k = 2; k < N; k++) begin
            advance = 1; tick(); advance = 0;
            chk_state("R3 advance step", 1 << k);
            check(state_idx == 3'(k), "R9 idx walk", int'(state_idx), k);
        end
        advance = 1; tick(); advance = 0;
        chk_state("R3 last step wraps to idle", 'h01);
        chk_flag("R5 no flag on legal walk", 0);
    endtask

    task automatic t_abort_r4();
        start = 1; tick(); start = 0;
        advance = 1; tick(); tick(); tick(); advance = 0;
        chk_state("R4 setup step4", 'h10);
        abort = 1; advance = 1; tick(); abort = 0; advance = 0;
        chk_state("R4 abort beats advance", 'h01);
        abort = 1; tick(); abort = 0;
        chk_state("R4 abort in idle ignored", 'h01);
    endtask

    task automatic t_clear_bit_r5_r7();
        flip_en = 1; flip_mask = 'h01; tick(); flip_en = 0; flip_mask = '0;
        chk_state("R10 bit cleared", 'h00);
        check(state_idx == 0, "R9 idx zero code", int'(state_idx), 0);
        chk_flag("R5 not early edge0", 0);
        tick();
        chk_flag("R5 not early edge1", 0);
        tick();
        chk_flag("R5 rises at LAT", 1);
        chk_state("R5 state still zero", 'h00);
        tick();
        chk_state("R6 idle reload", 'h01);
        chk_flag("R7 still high", 1);
        tick();
        chk_flag("R7 still high LAT+1", 1);
        tick();
        chk_flag("R7 cleared", 0);
        chk_state("R7 idle kept", 'h01);
    endtask

    task automatic t_extra_bit_r6();
        start = 1; tick(); start = 0;
        advance = 1; tick(); tick(); advance = 0;
        chk_state("R6 setup step3", 'h08);
        flip_en = 1; flip_mask = 'h20; advance = 1; tick(); flip_en = 0; flip_mask = '0;
        chk_state("R10 flip beats advance", 'h28);
        check(state_idx == 3, "R9 lowest bit", int'(state_idx), 3);
        tick();
        chk_state("R6 pair walks", 'h50);
        chk_flag("R5 not early", 0);
        tick();
        chk_flag("R5 extra bit flagged", 1);
        tick();
        chk_state("R6 alarm beats advance", 'h01);
        tick();
        chk_flag("R7 high LAT+1", 1);
        tick();
        advance = 0;
        chk_flag("R7 cleared after drain", 0);
        chk_state("R6 idle after drain", 'h01);
    endtask

    task automatic t_three_bits_r8();
        flip_en = 1; flip_mask = 'h06; tick(); flip_en = 0; flip_mask = '0;
        chk_state("R8 three bits set", 'h07);
        for (int k = 0; k < LAT + 2; k++) begin
            tick();
            chk_flag("R8 odd parity unflagged", 0);
        end
        do_reset();
        chk_state("R1 recovered", 'h01);
    endtask

    initial begin
        t_reset_r1();
        t_walk_r2_r3();
        t_abort_r4();
        t_clear_bit_r5_r7();
        t_extra_bit_r6();
        t_three_bits_r8();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule